// File: doc/BRIEF.md
# Four-Error Sector ECC Parity Loader and Byte Fixer

This block sits between the stored ECC bytes of a 512-byte sector and an external four-error syndrome and root-search engine. It accepts the ten stored ECC bytes one at a time and unpacks them into eight 10-bit parity words. It hands those words to the syndrome engine one per cycle, highest word first. A sector whose ECC bytes are all 0xFF is taken to be freshly erased, and it is left alone.

When the syndrome engine reports a nonzero syndrome, the block starts the search and follows the engine's state field through its busy phase, with each wait bounded by a timeout. Then it reads the reported count together with the error location and value pairs. For each location that maps into the sector, it performs a read-modify-write on the sector buffer and XORs the error value into the stored byte. Locations that map into the parity area are skipped.

A single `done` pulse ends every sector and carries a result code and the number of bytes repaired.

Top module: `ecc4_fixup`

## Requirements
- R1: After ten bytes are accepted on `eccValid`/`eccByte` (the first byte is byte 0), a sector whose ten bytes all equal 0xFF ends with result 3 (erased). It produces no `parLoad`, no `searchStart` and no buffer access.
- R2: For any other sector, bit j of parity word k (k = 0..7) is bit 10k+j of the byte stream, where byte 0 holds stream bits 7:0. The block presents the eight words on `parValue` with `parLoad` high for eight consecutive cycles, starting with word 7 and ending with word 0.
- R3: If `syndZero` is high in the cycle after the last parity word, the sector ends with result 0 (clean) and `searchStart` never rises.
- R4: Otherwise the block pulses `searchStart` for one cycle. It then waits until bits 3:2 of `srchState` become nonzero, and after that until they return to zero.
- R5: If either wait lasts `TIMEOUT_CYCLES` cycles (default 10240), the sector ends with result 2 (uncorrectable) and no buffer write is made.
- R6: Once the state has settled, a `srchState` value of 0 gives result 0 and a value of 1 gives result 2, with no buffer write in either case.
- R7: A settled state of 2 or 3 means `srchErrs`+1 errors are reported. Error i has its location at `errAddrs[10i+9:10i]` and its value at `errVals[8i+7:8i]`.
- R8: The byte index of an error is 519 minus its reported location. The fix is applied only when the location lies between 8 and 519 inclusive; other locations are skipped. The sector then ends with result 1 (fixed), and `fixCount` equals the number of bytes written.
- R9: Each fix takes two cycles. `bufRdEn` is high with `bufAddr` set to the index, and `bufRdData` must be valid in the next cycle. In that next cycle `bufWrEn` is high at the same address, with `bufWrData` equal to the read byte XOR the error value.
- R10: `done` is high for exactly one cycle per sector. `result` is encoded as 0 clean, 1 fixed, 2 uncorrectable, 3 erased.
- R11: During and right after reset, `done`, `parLoad`, `searchStart`, `bufRdEn` and `bufWrEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eccValid | input | 1 | Stored ECC byte valid |
| eccByte | input | 8 | Stored ECC byte, byte 0 first |
| parLoad | output | 1 | Parity word load strobe |
| parValue | output | 10 | Parity word being loaded |
| syndZero | input | 1 | Syndrome engine reports all-zero syndrome |
| searchStart | output | 1 | Starts the external correction search |
| srchState | input | 4 | Search engine state field |
| srchErrs | input | 2 | Reported error count minus one |
| errAddrs | input | 40 | Four 10-bit reported error locations |
| errVals | input | 32 | Four 8-bit error values |
| bufRdEn | output | 1 | Sector buffer read strobe |
| bufWrEn | output | 1 | Sector buffer write strobe |
| bufAddr | output | 9 | Sector buffer byte index |
| bufRdData | input | 8 | Buffer read data, one cycle after bufRdEn |
| bufWrData | output | 8 | Corrected byte to write |
| done | output | 1 | Sector finished pulse |
| result | output | 2 | Outcome code |
| fixCount | output | 3 | Number of bytes repaired |

## Verification
The hardest conditions to reach are the two timeouts and the mix of in-range and parity-area locations within one report. In the first timeout the search engine never raises its busy bits; in the second it raises them and never drops them. The bench contains a small search-engine model whose busy delay, settle delay, "never busy" and "never settle" behaviour are set for each sector, which drives both timeouts directly. Directed reports place locations exactly at 519, 8, 7 and above 519. Random sectors then vary the delays, the error count and the locations, and the bench compares the whole sector buffer against a reference copy.

// File: rtl/ecc4fix_pkg.sv
package ecc4fix_pkg;
  localparam int PAR_SEL_W = 3;
  localparam int ERR_SEL_W = 2;

  typedef enum logic [1:0] {
    RES_CLEAN  = 2'd0,
    RES_FIXED  = 2'd1,
    RES_UNCORR = 2'd2,
    RES_ERASED = 2'd3
  } fixResult_e;

  typedef struct packed {
    logic                 shiftByte;
    logic [PAR_SEL_W-1:0] parSel;
    logic [ERR_SEL_W-1:0] errSel;
  } dpCtrl_t;
endpackage

// File: rtl/ecc4fix_datapath.sv
module ecc4fix_datapath
  import ecc4fix_pkg::*;
#(
  parameter int ECC_BYTES    = 10,
  parameter int PAR_W        = 10,
  parameter int PAR_COUNT    = 8,
  parameter int ERR_MAX      = 4,
  parameter int SECTOR_BYTES = 512,
  localparam int STORE_W     = ECC_BYTES * 8,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtrl_t                ctl,
  input  logic [7:0]             eccByte,
  input  logic [ERR_MAX*PAR_W-1:0] errAddrs,
  input  logic [ERR_MAX*8-1:0]   errVals,
  input  logic [7:0]             bufRdData,
  output logic                   allErased,
  output logic [PAR_W-1:0]       parValue,
  output logic                   fixInRange,
  output logic [ADDR_W-1:0]      fixIndex,
  output logic [7:0]             fixWrData
);
  localparam int BIAS = SECTOR_BYTES + 7;
  localparam int DW   = ADDR_W + 3;

  logic [STORE_W-1:0] eccStore;
  logic [PAR_W-1:0]   parSlice [PAR_COUNT];
  logic [PAR_W-1:0]   errAddrSlice [ERR_MAX];
  logic [7:0]         errValSlice [ERR_MAX];
  logic [PAR_W-1:0]   rawAddr;
  logic [7:0]         rawVal;
  logic [DW-1:0]      biasDiff;

  always_ff @(posedge clk) begin
    if (!rstN) eccStore <= '0;
    else if (ctl.shiftByte) eccStore <= {eccByte, eccStore[STORE_W-1:8]};
  end

  assign allErased = &eccStore;

  for (genvar g = 0; g < PAR_COUNT; g++) begin : g_par
    assign parSlice[g] = eccStore[g*PAR_W +: PAR_W];
  end
  for (genvar e = 0; e < ERR_MAX; e++) begin : g_err
    assign errAddrSlice[e] = errAddrs[e*PAR_W +: PAR_W];
    assign errValSlice[e]  = errVals[e*8 +: 8];
  end

  assign parValue = parSlice[ctl.parSel];
  assign rawAddr  = errAddrSlice[ctl.errSel];
  assign rawVal   = errValSlice[ctl.errSel];
  assign biasDiff = DW'(BIAS) - DW'(rawAddr);

  // location must not exceed BIAS, and the index must land inside the sector
  assign fixInRange = (DW'(rawAddr) <= DW'(BIAS)) && (biasDiff < DW'(SECTOR_BYTES));
  assign fixIndex   = biasDiff[ADDR_W-1:0];
  assign fixWrData  = bufRdData ^ rawVal;

  // R2: a shift of a new byte never coincides with parity selection moving
  a_r2_store_stable_while_loading: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.parSel != $past(ctl.parSel)) |-> !$past(ctl.shiftByte));
endmodule

// File: rtl/ecc4fix_ctrl.sv
module ecc4fix_ctrl
  import ecc4fix_pkg::*;
#(
  parameter int ECC_BYTES      = 10,
  parameter int PAR_COUNT      = 8,
  parameter int TIMEOUT_CYCLES = 10240,
  localparam int CNT_W         = $clog2(ECC_BYTES),
  localparam int TMR_W         = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       eccValid,
  input  logic       syndZero,
  input  logic [3:0] srchState,
  input  logic [1:0] srchErrs,
  input  logic       allErased,
  input  logic       fixInRange,
  output dpCtrl_t    ctl,
  output logic       parLoad,
  output logic       searchStart,
  output logic       bufRdEn,
  output logic       bufWrEn,
  output logic       done,
  output fixResult_e result,
  output logic [2:0] fixCount
);
  typedef enum logic [3:0] {
    S_COLLECT, S_CHECK, S_LOAD, S_SYND, S_START, S_WAIT_BUSY,
    S_WAIT_SETTLE, S_DECIDE, S_FIX_RD, S_FIX_WR, S_DONE
  } state_e;

  state_e               state;
  logic [CNT_W-1:0]     byteCnt;
  logic [PAR_SEL_W-1:0] parSel;
  logic [ERR_SEL_W-1:0] errSel;
  logic [ERR_SEL_W-1:0] errLast;
  logic [TMR_W-1:0]     timer;
  logic                 busy;
  logic                 timedOut;

  assign busy     = |srchState[3:2];
  assign timedOut = (timer == TMR_W'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_COLLECT;
      byteCnt  <= '0;
      parSel   <= '0;
      errSel   <= '0;
      errLast  <= '0;
      timer    <= '0;
      result   <= RES_CLEAN;
      fixCount <= '0;
    end else begin
      case (state)
        S_COLLECT: if (eccValid) begin
          if (byteCnt == CNT_W'(ECC_BYTES - 1)) begin
            byteCnt <= '0;
            state   <= S_CHECK;
          end else byteCnt <= byteCnt + 1'b1;
        end
        S_CHECK: begin
          fixCount <= '0;
          if (allErased) begin
            result <= RES_ERASED;
            state  <= S_DONE;
          end else begin
            parSel <= PAR_SEL_W'(PAR_COUNT - 1);
            state  <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (parSel == '0) state <= S_SYND;
          else parSel <= parSel - 1'b1;
        end
        S_SYND: begin
          if (syndZero) begin
            result <= RES_CLEAN;
            state  <= S_DONE;
          end else state <= S_START;
        end
        S_START: begin
          timer <= '0;
          state <= S_WAIT_BUSY;
        end
        S_WAIT_BUSY: begin
          if (busy) begin
            timer <= '0;
            state <= S_WAIT_SETTLE;
          end else if (timedOut) begin
            result <= RES_UNCORR;
            state  <= S_DONE;
          end else timer <= timer + 1'b1;
        end
        S_WAIT_SETTLE: begin
          if (!busy) state <= S_DECIDE;
          else if (timedOut) begin
            result <= RES_UNCORR;
            state  <= S_DONE;
          end else timer <= timer + 1'b1;
        end
        S_DECIDE: begin
          case (srchState[1:0])
            2'd0: begin result <= RES_CLEAN;  state <= S_DONE; end
            2'd1: begin result <= RES_UNCORR; state <= S_DONE; end
            default: begin
              errLast <= srchErrs;
              errSel  <= '0;
              state   <= S_FIX_RD;
            end
          endcase
        end
        S_FIX_RD: begin
          if (fixInRange) state <= S_FIX_WR;
          else if (errSel == errLast) begin
            result <= RES_FIXED;
            state  <= S_DONE;
          end else errSel <= errSel + 1'b1;
        end
        S_FIX_WR: begin
          fixCount <= fixCount + 1'b1;
          if (errSel == errLast) begin
            result <= RES_FIXED;
            state  <= S_DONE;
          end else begin
            errSel <= errSel + 1'b1;
            state  <= S_FIX_RD;
          end
        end
        S_DONE:  state <= S_COLLECT;
        default: state <= S_COLLECT;
      endcase
    end
  end

  assign ctl.shiftByte = (state == S_COLLECT) && eccValid;
  assign ctl.parSel    = parSel;
  assign ctl.errSel    = errSel;
  assign parLoad       = (state == S_LOAD);
  assign searchStart   = (state == S_START);
  assign bufRdEn       = (state == S_FIX_RD) && fixInRange;
  assign bufWrEn       = (state == S_FIX_WR);
  assign done          = (state == S_DONE);

  // R9: every write is the second half of a read-modify-write
  a_r9_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> $past(bufRdEn));
  // R4: search only starts after a nonzero syndrome was reported
  a_r4_start_needs_syndrome: assert property (@(posedge clk) disable iff (!rstN)
    searchStart |-> $past(!syndZero));
  // R11: at most one strobe per cycle
  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({parLoad, searchStart, bufRdEn, bufWrEn, done}));
  // R8: repaired count never exceeds the four reportable errors
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (fixCount <= 3'd4));
endmodule

// File: rtl/ecc4_fixup.sv
module ecc4_fixup
  import ecc4fix_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 10240
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        eccValid,
  input  logic [7:0]  eccByte,
  output logic        parLoad,
  output logic [9:0]  parValue,
  input  logic        syndZero,
  output logic        searchStart,
  input  logic [3:0]  srchState,
  input  logic [1:0]  srchErrs,
  input  logic [39:0] errAddrs,
  input  logic [31:0] errVals,
  output logic        bufRdEn,
  output logic        bufWrEn,
  output logic [8:0]  bufAddr,
  input  logic [7:0]  bufRdData,
  output logic [7:0]  bufWrData,
  output logic        done,
  output logic [1:0]  result,
  output logic [2:0]  fixCount
);
  dpCtrl_t    ctl;
  logic       allErased;
  logic       fixInRange;
  fixResult_e resultEnum;

  ecc4fix_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk, .rstN, .eccValid, .syndZero, .srchState, .srchErrs,
    .allErased, .fixInRange, .ctl, .parLoad, .searchStart,
    .bufRdEn, .bufWrEn, .done, .result(resultEnum), .fixCount
  );

  ecc4fix_datapath u_dp (
    .clk, .rstN, .ctl, .eccByte, .errAddrs, .errVals, .bufRdData,
    .allErased, .parValue, .fixInRange, .fixIndex(bufAddr), .fixWrData(bufWrData)
  );

  assign result = resultEnum;

  // R9: write goes to the address that was just read
  a_r9_write_same_addr: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> (bufAddr == $past(bufAddr)));
endmodule

// File: tb/tb_ecc4_fixup.sv
module tb_ecc4_fixup;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eccValid = 1'b0;
  logic [7:0]  eccByte = '0;
  logic        parLoad, searchStart, bufRdEn, bufWrEn, done;
  logic [9:0]  parValue;
  logic        syndZero = 1'b0;
  logic [3:0]  srchState;
  logic [1:0]  srchErrs;
  logic [39:0] errAddrs = '0;
  logic [31:0] errVals = '0;
  logic [8:0]  bufAddr;
  logic [7:0]  bufRdData;
  logic [7:0]  bufWrData;
  logic [1:0]  result;
  logic [2:0]  fixCount;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ecc4_fixup dut (.*);

  // bench models
  logic       benchClr = 1'b0;
  int         salt = 0;
  int         mdlBusyDelay = 0, mdlSettleDelay = 0;
  logic       mdlNeverBusy = 1'b0, mdlNeverSettle = 1'b0;
  logic [1:0] mdlFinal = '0, mdlCnt = '0;
  logic [7:0] mem [512];
  logic [9:0] parLog [8];
  int         parCnt, startCnt, wrCnt, phase, tick;

  function automatic logic [7:0] patByte(int i, int s);
    return 8'(i * 37 + s * 11 + (i >> 3));
  endfunction

  always @(posedge clk) begin
    if (benchClr) begin
      for (int i = 0; i < 512; i++) mem[i] <= patByte(i, salt);
      parCnt <= 0; startCnt <= 0; wrCnt <= 0; phase <= 0; tick <= 0;
      srchState <= 4'd0; srchErrs <= 2'd0; bufRdData <= 8'd0;
    end else begin
      if (bufRdEn) bufRdData <= mem[bufAddr];
      if (bufWrEn) begin mem[bufAddr] <= bufWrData; wrCnt <= wrCnt + 1; end
      if (parLoad) begin
        if (parCnt < 8) parLog[parCnt] <= parValue;
        parCnt <= parCnt + 1;
      end
      if (searchStart) begin startCnt <= startCnt + 1; phase <= 1; tick <= 0; end
      else if (phase == 1) begin
        if (tick >= mdlBusyDelay && !mdlNeverBusy) begin srchState <= 4'h8; phase <= 2; tick <= 0; end
        else tick <= tick + 1;
      end else if (phase == 2) begin
        if (tick >= mdlSettleDelay && !mdlNeverSettle) begin
          srchState <= {2'b00, mdlFinal}; srchErrs <= mdlCnt; phase <= 0;
        end else tick <= tick + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] expPar(logic [79:0] s, int k);
    logic [9:0] r;
    for (int j = 0; j < 10; j++) r[j] = s[10*k + j];
    return r;
  endfunction

  task automatic runCase(input logic [79:0] stream, input logic sz, input logic [1:0] fin,
                         input logic [1:0] cnt, input logic [39:0] addrs, input logic [31:0] vals,
                         input int bDly, input int sDly, input logic nB, input logic nS);
    logic [7:0] expMem [512];
    int expRes, expWr, expStart, expPars, waitCyc, bad, n;
    bit erased;
    @(negedge clk);
    salt = salt + 1;
    syndZero = sz; mdlFinal = fin; mdlCnt = cnt; errAddrs = addrs; errVals = vals;
    mdlBusyDelay = bDly; mdlSettleDelay = sDly; mdlNeverBusy = nB; mdlNeverSettle = nS;
    benchClr = 1'b1;
    @(negedge clk);
    benchClr = 1'b0;
    for (int i = 0; i < 10; i++) begin
      eccValid = 1'b1; eccByte = stream[8*i +: 8];
      @(negedge clk);
    end
    eccValid = 1'b0;
    waitCyc = 0;
    while (!done && waitCyc < 25000) begin @(negedge clk); waitCyc++; end
    check(done == 1'b1, "R5 done reached", int'(done), 1);

    // expected outcome
    for (int i = 0; i < 512; i++) expMem[i] = patByte(i, salt);
    erased = (stream == {80{1'b1}});
    expWr = 0; expStart = 0; expPars = erased ? 0 : 8;
    if (erased) expRes = 3;
    else if (sz) expRes = 0;
    else begin
      expStart = 1;
      if (nB || nS) expRes = 2;
      else if (fin == 2'd0) expRes = 0;
      else if (fin == 2'd1) expRes = 2;
      else begin
        expRes = 1;
        n = int'(cnt) + 1;
        for (int e = 0; e < n; e++) begin
          int a;
          a = int'(addrs[10*e +: 10]);
          if (a >= 8 && a <= 519) begin
            expMem[519 - a] = expMem[519 - a] ^ vals[8*e +: 8];
            expWr++;
          end
        end
      end
    end
    check(int'(result) == expRes, "R10 result code (R1/R3/R6)", int'(result), expRes);
    check(int'(fixCount) == expWr || expRes != 1, "R8 fixCount", int'(fixCount), expWr);
    check(parCnt == expPars, "R2 parity load count", parCnt, expPars);
    if (expPars == 8)
      for (int j = 0; j < 8; j++)
        check(parLog[j] == expPar(stream, 7 - j), "R2 parity order/value", int'(parLog[j]),
              int'(expPar(stream, 7 - j)));
    check(startCnt == expStart, "R4 searchStart count", startCnt, expStart);
    check(wrCnt == expWr, "R9 buffer writes (R5/R6)", wrCnt, expWr);
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== expMem[i]) bad++;
    check(bad == 0, "R8 sector buffer contents", bad, 0);
    @(negedge clk);
    check(done == 1'b0, "R10 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [79:0] pat;
    void'($urandom(32'd2024));
    benchClr = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    check({done, parLoad, searchStart, bufRdEn, bufWrEn} == 5'd0, "R11 reset strobes",
          int'({done, parLoad, searchStart, bufRdEn, bufWrEn}), 0);
    rstN = 1'b1;
    benchClr = 1'b0;
    @(negedge clk);
    check({done, parLoad, searchStart, bufRdEn, bufWrEn} == 5'd0, "R11 after reset",
          int'({done, parLoad, searchStart, bufRdEn, bufWrEn}), 0);

    pat = 80'h1234_5678_9ABC_DEF0_0F1E;
    // R1 erased sector
    runCase({80{1'b1}}, 1'b0, 2'd3, 2'd3, {4{10'd300}}, 32'hFFFF_FFFF, 1, 1, 1'b0, 1'b0);
    // R3 one byte differs, zero syndrome
    runCase({8'hFE, {72{1'b1}}}, 1'b1, 2'd0, 2'd0, '0, '0, 0, 0, 1'b0, 1'b0);
    // R7 R8 four errors: index 0, index 511, parity area, middle
    runCase(pat, 1'b0, 2'd3, 2'd3, {10'd300, 10'd7, 10'd8, 10'd519},
            32'h5A_81_C3_01, 2, 3, 1'b0, 1'b0);
    // R8 location above 519 is skipped
    runCase(pat, 1'b0, 2'd2, 2'd0, {30'd0, 10'd520}, 32'h0000_00FF, 0, 0, 1'b0, 1'b0);
    // R6 too many errors and no error
    runCase(pat, 1'b0, 2'd1, 2'd2, {4{10'd100}}, 32'h1111_1111, 3, 2, 1'b0, 1'b0);
    runCase(pat, 1'b0, 2'd0, 2'd1, {4{10'd100}}, 32'h1111_1111, 1, 5, 1'b0, 1'b0);
    // R5 timeouts
    runCase(pat, 1'b0, 2'd3, 2'd0, {30'd0, 10'd200}, 32'h0000_0042, 0, 0, 1'b1, 1'b0);
    runCase(pat, 1'b0, 2'd3, 2'd0, {30'd0, 10'd200}, 32'h0000_0042, 2, 0, 1'b0, 1'b1);
    // R7 random reports
    for (int r = 0; r < 24; r++) begin
      logic [79:0] s;
      logic [39:0] a;
      s = {16'($urandom), $urandom, $urandom};
      for (int e = 0; e < 4; e++) a[10*e +: 10] = 10'($urandom_range(0, 560));
      runCase(s, ($urandom_range(0, 7) == 0), 2'($urandom_range(1, 3)), 2'($urandom),
              a, $urandom, $urandom_range(0, 20), $urandom_range(0, 20), 1'b0, 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule